// File: doc/BRIEF.md
# Static Memory Strobe Timing Generator

This block runs single accesses to one external asynchronous static memory. A host presents a request (direction, address, byte enables, write data) and holds it until the block returns a one-clock acknowledge; read data is valid from that acknowledge onward. During an access the block drives the address and active-low byte selects. It also generates an active-low chip select, a read strobe and a write strobe. Each low window is positioned by a setup count and a pulse count, both measured from the first clock of the access. The access lasts a programmable number of clocks.

Every timing value arrives as a short code that expands into a larger clock count. The top bit or bits of the code add a large fixed offset, so long strobes and long accesses can be programmed with few bits. Reads and writes each have their own setup and pulse for the data strobe and for the chip select, and their own cycle length. When an access goes in the opposite direction from the one before it, the block adds one quiet clock first so that the data bus can turn around. The block does not check configuration values. A pulse of zero, or a setup plus pulse longer than the cycle, is a host error. The configuration inputs must stay stable while an access is in progress.

Top module: `srm_timing_ctrl`

## Requirements
- R1: After reset, mem_cs_n, mem_oe_n and mem_we_n are high, mem_dout_en and req_ack are low, and rsp_rdata is zero.
- R2: A 6-bit setup code c expands to 128 * c[5] + c[4:0] clocks, which gives 0..31 or 128..159.
- R3: A 7-bit pulse code c expands to 256 * c[6] + c[5:0] clocks, which gives 0..63 or 256..319.
- R4: A 9-bit cycle code c expands to N = 256 * c[8:7] + c[6:0] clocks. The access occupies N consecutive clocks, and req_ack is high for exactly one clock, the clock right after the last access clock.
- R5: Number the access clocks 0..N-1. The direction's data strobe (mem_oe_n for req_write=0, mem_we_n for req_write=1) is low exactly in clocks S..S+P-1, using that direction's strobe setup S and strobe pulse P. mem_cs_n is low exactly in clocks over the same kind of window, built from that direction's select setup and select pulse. The strobe of the other direction stays high. All three lines are high outside an access.
- R6: Read data is sampled from mem_din on the clock edge that ends the last clock with mem_oe_n low. It appears on rsp_rdata from the acknowledge clock and holds until the next sample.
- R7: A request is taken on a clock edge at which the block is idle and req_valid is high. Access clock 0 follows that edge directly if the access is the first one after reset or has the same direction as the previous access. If the direction differs, exactly one extra clock with all strobes high comes first.
- R8: For writes, mem_dout_en is high from access clock 0 through the acknowledge clock, and low at all other times. mem_addr, mem_be_n (active low, bit i for byte i) and mem_dout change only on the edge that takes a request. They therefore remain valid after mem_we_n rises, even with zero write hold.
- R9: mem_oe_n and mem_we_n are never low together, and mem_oe_n is never low while mem_dout_en is high.
- R10: A request that is still held high during the acknowledge clock is not taken again on the edge that ends that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until req_ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_be | input | BW | Byte enables, active high |
| req_wdata | input | DW | Write data |
| req_ack | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DW | Sampled read data |
| rd_strb_setup_code | input | 6 | Read strobe setup code |
| rd_sel_setup_code | input | 6 | Chip select setup code for reads |
| wr_strb_setup_code | input | 6 | Write strobe setup code |
| wr_sel_setup_code | input | 6 | Chip select setup code for writes |
| rd_strb_pulse_code | input | 7 | Read strobe pulse code |
| rd_sel_pulse_code | input | 7 | Chip select pulse code for reads |
| wr_strb_pulse_code | input | 7 | Write strobe pulse code |
| wr_sel_pulse_code | input | 7 | Chip select pulse code for writes |
| rd_cycle_code | input | 9 | Read access length code |
| wr_cycle_code | input | 9 | Write access length code |
| mem_addr | output | AW | Memory address |
| mem_be_n | output | BW | Byte selects, active low |
| mem_dout | output | DW | Write data toward memory |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | DW | Read data from memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |

## Verification
If the access counter or the decoded parameters go wrong, a strobe edge shows up on the wrong clock within the same access. A wrong stretch of the cycle length moves the acknowledge by the same number of clocks. Mistakes in the state sequence or in the stored direction become visible at the next request: a turnaround clock is missing or added, or a new access starts during the acknowledge clock. A capture that is off by one clock shows up in rsp_rdata at the acknowledge, because the bench changes mem_din on every clock. The reference model predicts every strobe and acknowledge level for every clock, so any of these faults is reported on the first clock where it changes a port.

// File: rtl/srm_pkg.sv
package srm_pkg;
  localparam int SETUP_CODE_W = 6;
  localparam int SETUP_LOW_W  = 5;
  localparam int SETUP_SHIFT  = 7;
  localparam int SETUP_EFF_W  = 8;

  localparam int PULSE_CODE_W = 7;
  localparam int PULSE_LOW_W  = 6;
  localparam int PULSE_SHIFT  = 8;
  localparam int PULSE_EFF_W  = 9;

  localparam int CYCLE_CODE_W = 9;
  localparam int CYCLE_LOW_W  = 7;
  localparam int CYCLE_SHIFT  = 8;
  localparam int CYCLE_EFF_W  = 10;

  // wide enough for setup + pulse of the largest codes
  localparam int CNT_W = 11;

  // strobe slots: data strobe and chip select, per direction
  localparam int N_SLOT   = 4;
  localparam int SLOT_RDS = 0;
  localparam int SLOT_RCS = 1;
  localparam int SLOT_WRS = 2;
  localparam int SLOT_WCS = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TURN,
    ST_ACCESS,
    ST_DONE
  } acc_state_e;
endpackage

// File: rtl/srm_code_expand.sv
module srm_code_expand #(
  parameter int CODE_W = 6,
  parameter int LOW_W  = 5,
  parameter int SHIFT  = 7,
  parameter int EFF_W  = 8
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [EFF_W-1:0]  eff_o
);
  localparam int HIGH_W = CODE_W - LOW_W;

  logic [HIGH_W-1:0] high_bits;
  logic [LOW_W-1:0]  low_bits;

  assign high_bits = code_i[CODE_W-1:LOW_W];
  assign low_bits  = code_i[LOW_W-1:0];
  // upper bits add a coarse offset, lower bits a fine count
  assign eff_o = (EFF_W'(high_bits) << SHIFT) | EFF_W'(low_bits);
endmodule

// File: rtl/srm_strobe_window.sv
module srm_strobe_window
  import srm_pkg::*;
(
  input  logic                   active_i,
  input  logic [CNT_W-1:0]       cnt_i,
  input  logic [SETUP_EFF_W-1:0] setup_i,
  input  logic [PULSE_EFF_W-1:0] pulse_i,
  output logic                   on_o
);
  logic [CNT_W-1:0] first_clk;
  logic [CNT_W-1:0] end_clk;

  assign first_clk = CNT_W'(setup_i);
  assign end_clk   = first_clk + CNT_W'(pulse_i);
  assign on_o      = active_i && (cnt_i >= first_clk) && (cnt_i < end_clk);
endmodule

// File: rtl/srm_access_fsm.sv
module srm_access_fsm
  import srm_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid_i,
  input  logic                   req_write_i,
  input  logic [CYCLE_EFF_W-1:0] rd_cycle_i,
  input  logic [CYCLE_EFF_W-1:0] wr_cycle_i,
  output logic                   load_o,
  output logic                   dir_sel_o,
  output logic                   dir_o,
  output acc_state_e             state_o,
  output acc_state_e             state_nxt_o,
  output logic [CNT_W-1:0]       cnt_o,
  output logic [CNT_W-1:0]       cnt_nxt_o
);
  acc_state_e             state_q, state_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   dir_q;
  logic                   seen_q;
  logic [CYCLE_EFF_W-1:0] cyc_len;
  logic                   last_clk;

  assign load_o    = (state_q == ST_IDLE) && req_valid_i;
  assign dir_sel_o = load_o ? req_write_i : dir_q;
  assign cyc_len   = dir_q ? wr_cycle_i : rd_cycle_i;
  // a zero length behaves as one clock
  assign last_clk  = (cnt_q + 1'b1) >= CNT_W'(cyc_len);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          cnt_d   = '0;
          state_d = (seen_q && (req_write_i != dir_q)) ? ST_TURN : ST_ACCESS;
        end
      end
      ST_TURN: begin
        cnt_d   = '0;
        state_d = ST_ACCESS;
      end
      ST_ACCESS: begin
        if (last_clk) state_d = ST_DONE;
        else          cnt_d   = cnt_q + 1'b1;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (load_o) begin
        dir_q  <= req_write_i;
        seen_q <= 1'b1;
      end
    end
  end

  assign dir_o       = dir_q;
  assign state_o     = state_q;
  assign state_nxt_o = state_d;
  assign cnt_o       = cnt_q;
  assign cnt_nxt_o   = cnt_d;
endmodule

// File: rtl/srm_timing_ctrl.sv
module srm_timing_ctrl
  import srm_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int BW = DW / 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [AW-1:0]           req_addr,
  input  logic [BW-1:0]           req_be,
  input  logic [DW-1:0]           req_wdata,
  output logic                    req_ack,
  output logic [DW-1:0]           rsp_rdata,
  input  logic [SETUP_CODE_W-1:0] rd_strb_setup_code,
  input  logic [SETUP_CODE_W-1:0] rd_sel_setup_code,
  input  logic [SETUP_CODE_W-1:0] wr_strb_setup_code,
  input  logic [SETUP_CODE_W-1:0] wr_sel_setup_code,
  input  logic [PULSE_CODE_W-1:0] rd_strb_pulse_code,
  input  logic [PULSE_CODE_W-1:0] rd_sel_pulse_code,
  input  logic [PULSE_CODE_W-1:0] wr_strb_pulse_code,
  input  logic [PULSE_CODE_W-1:0] wr_sel_pulse_code,
  input  logic [CYCLE_CODE_W-1:0] rd_cycle_code,
  input  logic [CYCLE_CODE_W-1:0] wr_cycle_code,
  output logic [AW-1:0]           mem_addr,
  output logic [BW-1:0]           mem_be_n,
  output logic [DW-1:0]           mem_dout,
  output logic                    mem_dout_en,
  input  logic [DW-1:0]           mem_din,
  output logic                    mem_cs_n,
  output logic                    mem_oe_n,
  output logic                    mem_we_n
);
  // ---------------- code expansion ----------------
  logic [SETUP_CODE_W-1:0] setup_code [N_SLOT];
  logic [PULSE_CODE_W-1:0] pulse_code [N_SLOT];
  logic [SETUP_EFF_W-1:0]  setup_eff  [N_SLOT];
  logic [PULSE_EFF_W-1:0]  pulse_eff  [N_SLOT];
  logic [CYCLE_CODE_W-1:0] cycle_code [2];
  logic [CYCLE_EFF_W-1:0]  cycle_eff  [2];

  assign setup_code[SLOT_RDS] = rd_strb_setup_code;
  assign setup_code[SLOT_RCS] = rd_sel_setup_code;
  assign setup_code[SLOT_WRS] = wr_strb_setup_code;
  assign setup_code[SLOT_WCS] = wr_sel_setup_code;
  assign pulse_code[SLOT_RDS] = rd_strb_pulse_code;
  assign pulse_code[SLOT_RCS] = rd_sel_pulse_code;
  assign pulse_code[SLOT_WRS] = wr_strb_pulse_code;
  assign pulse_code[SLOT_WCS] = wr_sel_pulse_code;
  assign cycle_code[0]        = rd_cycle_code;
  assign cycle_code[1]        = wr_cycle_code;

  for (genvar gi = 0; gi < N_SLOT; gi++) begin : g_slot
    srm_code_expand #(
      .CODE_W(SETUP_CODE_W), .LOW_W(SETUP_LOW_W),
      .SHIFT(SETUP_SHIFT),   .EFF_W(SETUP_EFF_W)
    ) u_setup (
      .code_i(setup_code[gi]),
      .eff_o (setup_eff[gi])
    );
    srm_code_expand #(
      .CODE_W(PULSE_CODE_W), .LOW_W(PULSE_LOW_W),
      .SHIFT(PULSE_SHIFT),   .EFF_W(PULSE_EFF_W)
    ) u_pulse (
      .code_i(pulse_code[gi]),
      .eff_o (pulse_eff[gi])
    );
  end

  for (genvar gd = 0; gd < 2; gd++) begin : g_cycle
    srm_code_expand #(
      .CODE_W(CYCLE_CODE_W), .LOW_W(CYCLE_LOW_W),
      .SHIFT(CYCLE_SHIFT),   .EFF_W(CYCLE_EFF_W)
    ) u_cycle (
      .code_i(cycle_code[gd]),
      .eff_o (cycle_eff[gd])
    );
  end

  // ---------------- sequencing ----------------
  logic             load;
  logic             dir_sel;
  logic             dir_q;
  acc_state_e       state_q;
  acc_state_e       state_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  srm_access_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid_i(req_valid),
    .req_write_i(req_write),
    .rd_cycle_i (cycle_eff[0]),
    .wr_cycle_i (cycle_eff[1]),
    .load_o     (load),
    .dir_sel_o  (dir_sel),
    .dir_o      (dir_q),
    .state_o    (state_q),
    .state_nxt_o(state_d),
    .cnt_o      (cnt_q),
    .cnt_nxt_o  (cnt_d)
  );

  // ---------------- strobe windows (next-clock view) ----------------
  logic                   nxt_active;
  logic [SETUP_EFF_W-1:0] strb_setup;
  logic [PULSE_EFF_W-1:0] strb_pulse;
  logic [SETUP_EFF_W-1:0] sel_setup;
  logic [PULSE_EFF_W-1:0] sel_pulse;
  logic                   strb_on;
  logic                   sel_on;

  assign nxt_active = (state_d == ST_ACCESS);
  assign strb_setup = dir_sel ? setup_eff[SLOT_WRS] : setup_eff[SLOT_RDS];
  assign strb_pulse = dir_sel ? pulse_eff[SLOT_WRS] : pulse_eff[SLOT_RDS];
  assign sel_setup  = dir_sel ? setup_eff[SLOT_WCS] : setup_eff[SLOT_RCS];
  assign sel_pulse  = dir_sel ? pulse_eff[SLOT_WCS] : pulse_eff[SLOT_RCS];

  srm_strobe_window u_strb_win (
    .active_i(nxt_active),
    .cnt_i   (cnt_d),
    .setup_i (strb_setup),
    .pulse_i (strb_pulse),
    .on_o    (strb_on)
  );

  srm_strobe_window u_sel_win (
    .active_i(nxt_active),
    .cnt_i   (cnt_d),
    .setup_i (sel_setup),
    .pulse_i (sel_pulse),
    .on_o    (sel_on)
  );

  // ---------------- read sample point ----------------
  logic [CNT_W-1:0] rd_last_clk;
  logic             rd_sample;

  assign rd_last_clk = CNT_W'(setup_eff[SLOT_RDS]) + CNT_W'(pulse_eff[SLOT_RDS]) - 1'b1;
  assign rd_sample   = (state_q == ST_ACCESS) && !dir_q && (cnt_q == rd_last_clk);

  // ---------------- registered outputs ----------------
  logic          cs_n_q, oe_n_q, we_n_q, den_q;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] be_n_q;
  logic [DW-1:0] dout_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      den_q   <= 1'b0;
      addr_q  <= '0;
      be_n_q  <= '1;
      dout_q  <= '0;
      rdata_q <= '0;
    end else begin
      cs_n_q <= !sel_on;
      oe_n_q <= !(strb_on && !dir_sel);
      we_n_q <= !(strb_on && dir_sel);
      den_q  <= dir_sel && ((state_d == ST_ACCESS) || (state_d == ST_DONE));
      if (load) begin
        addr_q <= req_addr;
        be_n_q <= ~req_be;
        dout_q <= req_wdata;
      end
      if (rd_sample) rdata_q <= mem_din;
    end
  end

  assign req_ack     = (state_q == ST_DONE);
  assign rsp_rdata   = rdata_q;
  assign mem_addr    = addr_q;
  assign mem_be_n    = be_n_q;
  assign mem_dout    = dout_q;
  assign mem_dout_en = den_q;
  assign mem_cs_n    = cs_n_q;
  assign mem_oe_n    = oe_n_q;
  assign mem_we_n    = we_n_q;
endmodule

// File: rtl/srm_timing_ctrl_chk.sv
module srm_timing_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ack,
  input logic          mem_cs_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dout_en,
  input logic [AW-1:0] mem_addr
);
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n)); // R9
  AST_NO_READ_WHILE_DRIVING: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dout_en); // R9
  AST_WRITE_STROBE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_dout_en); // R8
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack); // R4
  AST_ACK_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ack |-> (mem_cs_n && mem_oe_n && mem_we_n)); // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr)); // R8
endmodule

bind srm_timing_ctrl srm_timing_ctrl_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_ack    (req_ack),
  .mem_cs_n   (mem_cs_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_dout_en(mem_dout_en),
  .mem_addr   (mem_addr)
);

// File: tb/srm_timing_ctrl_test.sv
module srm_timing_ctrl_test;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int BW = DW / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic [BW-1:0] req_be    = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ack;
  logic [DW-1:0] rsp_rdata;
  logic [5:0]    rd_ss = '0, rd_cs = '0, wr_ss = '0, wr_cs = '0;
  logic [6:0]    rd_sp = 7'd1, rd_cp = 7'd1, wr_sp = 7'd1, wr_cp = 7'd1;
  logic [8:0]    rd_cy = 9'd1, wr_cy = 9'd1;
  logic [AW-1:0] mem_addr;
  logic [BW-1:0] mem_be_n;
  logic [DW-1:0] mem_dout;
  logic          mem_dout_en;
  logic [DW-1:0] mem_din = '0;
  logic          mem_cs_n, mem_oe_n, mem_we_n;

  srm_timing_ctrl #(.AW(AW), .DW(DW), .BW(BW)) uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .req_ack(req_ack), .rsp_rdata(rsp_rdata),
    .rd_strb_setup_code(rd_ss), .rd_sel_setup_code(rd_cs),
    .wr_strb_setup_code(wr_ss), .wr_sel_setup_code(wr_cs),
    .rd_strb_pulse_code(rd_sp), .rd_sel_pulse_code(rd_cp),
    .wr_strb_pulse_code(wr_sp), .wr_sel_pulse_code(wr_cp),
    .rd_cycle_code(rd_cy), .wr_cycle_code(wr_cy),
    .mem_addr(mem_addr), .mem_be_n(mem_be_n), .mem_dout(mem_dout),
    .mem_dout_en(mem_dout_en), .mem_din(mem_din),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
  );

  int checks = 0;
  int errors = 0;
  // expected per-clock item: {turn, sample, ack, den, we_n, oe_n, cs_n}
  logic [6:0]    exp_q[$];
  bit            seen = 0;
  bit            last_dir = 0;
  bit            cur_dir;
  logic [AW-1:0] cur_addr;
  logic [BW-1:0] cur_be;
  logic [DW-1:0] cur_wd;
  logic [DW-1:0] exp_rd = '0;
  int            din_seq = 1;

  function automatic int dec_setup(int c); return (c / 32) * 128 + (c % 32); endfunction
  function automatic int dec_pulse(int c); return (c / 64) * 256 + (c % 64); endfunction
  function automatic int dec_cycle(int c); return (c / 128) * 256 + (c % 128); endfunction

  task automatic fail_line(string tag, int act, int exp);
    errors++;
    $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
  endtask

  // called at a falling edge: compare this clock, then advance mem_din
  task automatic step(output logic [6:0] e);
    logic [4:0] got;
    e   = (exp_q.size() > 0) ? exp_q.pop_front() : 7'b0000111;
    got = {req_ack, mem_dout_en, mem_we_n, mem_oe_n, mem_cs_n};
    checks++;
    if (got !== e[4:0]) begin
      if (e[6])                 fail_line("R7 turnaround clock", int'(got), int'(e[4:0]));
      else if (got[4] !== e[4]) fail_line("R4 ack timing", int'(got), int'(e[4:0]));
      else if (got[3] !== e[3]) fail_line("R8 data drive", int'(got), int'(e[4:0]));
      else                      fail_line("R2 R3 R5 strobe window", int'(got), int'(e[4:0]));
    end
    checks++;
    if ((!mem_oe_n && !mem_we_n) || (!mem_oe_n && mem_dout_en))
      fail_line("R9 strobe conflict", int'(got), 7);
    if (e[4]) begin
      checks++;
      if (mem_addr !== cur_addr) fail_line("R8 address held", int'(mem_addr), int'(cur_addr));
      checks++;
      if (mem_be_n !== ~cur_be) fail_line("R8 byte selects", int'(mem_be_n), int'(~cur_be));
      checks++;
      if (cur_dir) begin
        if (mem_dout !== cur_wd) fail_line("R8 write data held", int'(mem_dout), int'(cur_wd));
      end else begin
        if (rsp_rdata !== exp_rd) fail_line("R6 read sample", int'(rsp_rdata), int'(exp_rd));
      end
    end
    mem_din = DW'(din_seq * 97 + 13);
    din_seq++;
    if (e[5]) exp_rd = mem_din;
  endtask

  task automatic access(bit wr, logic [AW-1:0] a, logic [BW-1:0] be,
                        logic [DW-1:0] wd, bit hold);
    logic [6:0] e;
    int s, p, cs, cp, n;
    @(negedge clk); step(e);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
    cur_dir = wr; cur_addr = a; cur_be = be; cur_wd = wd;
    s  = dec_setup(int'(wr ? wr_ss : rd_ss));
    cs = dec_setup(int'(wr ? wr_cs : rd_cs));
    p  = dec_pulse(int'(wr ? wr_sp : rd_sp));
    cp = dec_pulse(int'(wr ? wr_cp : rd_cp));
    n  = dec_cycle(int'(wr ? wr_cy : rd_cy));
    if (seen && (wr != last_dir)) exp_q.push_back(7'b1000111);
    for (int t = 0; t < n; t++) begin
      bit sl, cl, smp;
      sl  = (t >= s) && (t < s + p);
      cl  = (t >= cs) && (t < cs + cp);
      smp = !wr && (t == s + p - 1);
      exp_q.push_back({1'b0, smp, 1'b0, wr, !(wr && sl), !(!wr && sl), !cl});
    end
    exp_q.push_back({2'b00, 1'b1, wr, 3'b111});
    seen = 1; last_dir = wr;
    do begin
      @(negedge clk); step(e);
    end while (!e[4]);
    if (hold) begin
      // request still high through the ack clock; must not start again
      @(negedge clk); step(e);
      checks++;
      if (!(mem_cs_n && mem_oe_n && mem_we_n && !req_ack))
        fail_line("R10 no retake in ack clock",
                  int'({req_ack, mem_we_n, mem_oe_n, mem_cs_n}), 7);
    end
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fail_line("watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [6:0] e;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    checks++;
    if (!(mem_cs_n && mem_oe_n && mem_we_n && !mem_dout_en && !req_ack && rsp_rdata == '0))
      fail_line("R1 reset state", int'({mem_dout_en, req_ack, mem_we_n, mem_oe_n, mem_cs_n}), 7);

    // set A: small plain codes
    rd_ss = 6'd2; rd_cs = 6'd1; rd_sp = 7'd3; rd_cp = 7'd5; rd_cy = 9'd8;
    wr_ss = 6'd1; wr_cs = 6'd0; wr_sp = 7'd4; wr_cp = 7'd6; wr_cy = 9'd7;
    access(0, 16'h1234, 2'b11, 16'h0000, 0);
    access(0, 16'h0042, 2'b01, 16'h0000, 0);  // same direction, R7 no gap
    access(1, 16'h0100, 2'b10, 16'hBEEF, 0);  // turnaround
    access(1, 16'h0102, 2'b01, 16'h5A5A, 1);  // R10 held request
    access(0, 16'h0200, 2'b11, 16'h0000, 0);

    // set B: zero write hold
    wr_ss = 6'd2; wr_sp = 7'd3; wr_cy = 9'd5; wr_cs = 6'd0; wr_cp = 7'd5;
    access(1, 16'h0300, 2'b11, 16'hC0DE, 0);

    // set C: offset bits set
    rd_ss = 6'b100001; rd_cs = 6'b000000; rd_sp = 7'b1000010; rd_cp = 7'b1111111;
    rd_cy = 9'b100000000;
    wr_ss = 6'b100000; wr_cs = 6'b000011; wr_sp = 7'b1111111; wr_cp = 7'b1000101;
    wr_cy = 9'b110000101;
    access(0, 16'h4000, 2'b11, 16'h0000, 0);
    access(1, 16'h4002, 2'b11, 16'h1357, 0);

    // set D: largest low-bit codes and the minimal access
    rd_ss = 6'd31; rd_sp = 7'd63; rd_cy = 9'd127; rd_cs = 6'd0; rd_cp = 7'd63;
    wr_ss = 6'd0; wr_sp = 7'd1; wr_cy = 9'd1; wr_cs = 6'd0; wr_cp = 7'd1;
    access(0, 16'h7FFE, 2'b10, 16'h0000, 0);
    access(1, 16'h0001, 2'b01, 16'h00FF, 0);
    access(1, 16'h0003, 2'b10, 16'hFF00, 0);
    rd_ss = 6'd0; rd_sp = 7'd1; rd_cy = 9'd1; rd_cp = 7'd1;
    access(0, 16'h0005, 2'b11, 16'h0000, 0);

    repeat (3) begin @(negedge clk); step(e); end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule